// File: doc/BRIEF.md
# Omega Multistage Switching Network

This block is an 8-by-8 omega network for one routing cycle at a time. Each input carries a valid flag, a 3-bit destination number and a data word. The network has three stages of 2x2 switches. In front of every stage a fixed perfect-shuffle wiring moves line `i` to the line whose number is `i` rotated left by one bit inside the 3-bit field. Each switch takes one bit of the destination tag, most significant bit first, and sets itself from that bit. After the last stage, a message that won every switch it passed through sits on the output line equal to its destination.

A switch has two named settings, `SW_PASS` and `SW_CROSS`, held in the enum `sw_set_e`. The switch picks `SW_PASS` when its upper input is valid and asks for the upper output. It picks `SW_CROSS` when its upper input is valid and asks for the lower output. If only the lower input is valid, the setting is the one that sends that message where it asks to go. With no valid input the switch rests in `SW_PASS`. The setting is re-derived from the current inputs on every cycle and is never stored, so a switch can move from any setting to the other between any two cycles.

When both messages at a switch want the same output, the message on the upper input wins. The message on the lower input is dropped, and the blocked flag of its source port is raised. Delivered words and blocked flags are registered. The network keeps no message from one cycle to the next.

Top module: `omega_net`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_data` and `blocked` are all zero, even if traffic was flowing just before.
- R2: A single valid message from any input to any destination appears on `out_valid[dest]` with its payload on `out_data` one clock edge after it is sampled, and no `blocked` bit is set.
- R3: Before each stage, line i is wired to line rotl(i). As a result the identity pattern and the cyclic shifts dest = (src + c) mod 8 deliver all eight messages with no blocking.
- R4: At stage k the switch reads destination bit (2-k). A 0 leaves on the upper output (even line) and a 1 leaves on the lower output (odd line). Two messages whose tags separate them at the first stage, src0->1 and src3->6, both arrive.
- R5: When two valid messages at one switch ask for the same output, the message on the upper (lower-numbered) input line wins. `blocked[src]` of the loser is set for that cycle. Example: src2->7 together with src6->4 delivers src2 on output 7 and sets `blocked[6]`.
- R6: An invalid input never sets a switch, never causes a conflict and never produces data. Output words whose `out_valid` bit is 0 read as zero. Example: src6->4 alone, with input 2 invalid but tagged 7, is delivered on output 4 with no blocking.
- R7: In every cycle, the number of set `out_valid` bits plus the number of set `blocked` bits equals the number of valid inputs one cycle earlier.
- R8: Results depend only on the inputs sampled at the previous edge. A cycle with no valid inputs gives all-zero `out_valid` and `blocked`, whatever came before.
- R9: With all eight inputs aimed at output 7, only input 0 is delivered, and `blocked` reads 8'hFE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 8 | Per-input message valid |
| in_dest | input | 24 | Destination of input i in bits [3i+2:3i] |
| in_data | input | 64 | Payload of input i in bits [8i+7:8i] |
| out_valid | output | 8 | Output o received a message |
| out_data | output | 64 | Payload on output o in bits [8o+7:8o], zero when not valid |
| blocked | output | 8 | Bit s set: the message from input s lost a link conflict |

## Verification
Every result of this block is due at exactly one rising edge after its inputs are sampled. The routing, the switch settings and the arbitration are all combinational in front of a single register rank. The bench therefore changes the inputs on a falling edge and reads `out_valid`, `out_data` and `blocked` on the next falling edge, which falls half a cycle after the capturing rising edge. The reset check reads the outputs while `rst_n` is still held low. The idle check reads them one falling edge after an all-invalid input pattern is applied.

// File: rtl/omega_pkg.sv
package omega_pkg;

    // Setting of one 2x2 switching element.
    typedef enum logic {
        SW_PASS  = 1'b0,
        SW_CROSS = 1'b1
    } sw_set_e;

    // One-bit left rotation of v inside a w-bit field (perfect shuffle).
    function automatic int rotl(input int v, input int w);
        int m;
        m = (1 << w) - 1;
        return ((v << 1) | (v >> (w - 1))) & m;
    endfunction

endpackage

// File: rtl/omega_switch.sv
module omega_switch
    import omega_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3,
    parameter int BIT    = 2
) (
    input  logic              a_vld,
    input  logic [ADDR_W-1:0] a_dst,
    input  logic [DATA_W-1:0] a_dat,
    input  logic [ADDR_W-1:0] a_src,
    input  logic              b_vld,
    input  logic [ADDR_W-1:0] b_dst,
    input  logic [DATA_W-1:0] b_dat,
    input  logic [ADDR_W-1:0] b_src,
    output logic              u_vld,
    output logic [ADDR_W-1:0] u_dst,
    output logic [DATA_W-1:0] u_dat,
    output logic [ADDR_W-1:0] u_src,
    output logic              l_vld,
    output logic [ADDR_W-1:0] l_dst,
    output logic [DATA_W-1:0] l_dat,
    output logic [ADDR_W-1:0] l_src,
    output logic              b_lost
);

    sw_set_e setting;
    logic    b_live;

    // Upper input has priority; lower input only steers an idle switch.
    always_comb begin
        if (a_vld)
            setting = a_dst[BIT] ? SW_CROSS : SW_PASS;
        else if (b_vld)
            setting = b_dst[BIT] ? SW_PASS : SW_CROSS;
        else
            setting = SW_PASS;
        b_lost = a_vld & b_vld & (a_dst[BIT] == b_dst[BIT]);
        b_live = b_vld & ~b_lost;
    end

    always_comb begin
        unique case (setting)
            SW_PASS: begin
                u_vld = a_vld;  u_dst = a_dst; u_dat = a_dat; u_src = a_src;
                l_vld = b_live; l_dst = b_dst; l_dat = b_dat; l_src = b_src;
            end
            SW_CROSS: begin
                u_vld = b_live; u_dst = b_dst; u_dat = b_dat; u_src = b_src;
                l_vld = a_vld;  l_dst = a_dst; l_dat = a_dat; l_src = a_src;
            end
            default: begin
                u_vld = 1'b0; u_dst = '0; u_dat = '0; u_src = '0;
                l_vld = 1'b0; l_dst = '0; l_dat = '0; l_src = '0;
            end
        endcase
    end

endmodule

// File: rtl/omega_stage.sv
module omega_stage
    import omega_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3,
    parameter int BIT    = 2,
    localparam int N     = 1 << ADDR_W
) (
    input  logic [N-1:0]        i_vld,
    input  logic [N*ADDR_W-1:0] i_dst,
    input  logic [N*DATA_W-1:0] i_dat,
    input  logic [N*ADDR_W-1:0] i_src,
    output logic [N-1:0]        o_vld,
    output logic [N*ADDR_W-1:0] o_dst,
    output logic [N*DATA_W-1:0] o_dat,
    output logic [N*ADDR_W-1:0] o_src,
    output logic [N-1:0]        o_blk
);

    logic [N-1:0]        sh_vld;
    logic [N*ADDR_W-1:0] sh_dst;
    logic [N*DATA_W-1:0] sh_dat;
    logic [N*ADDR_W-1:0] sh_src;
    logic [N/2-1:0]      lost;

    // Perfect-shuffle wiring in front of the switch column.
    for (genvar i = 0; i < N; i++) begin : g_shuf
        localparam int P = rotl(i, ADDR_W);
        assign sh_vld[P]                   = i_vld[i];
        assign sh_dst[P*ADDR_W +: ADDR_W]  = i_dst[i*ADDR_W +: ADDR_W];
        assign sh_dat[P*DATA_W +: DATA_W]  = i_dat[i*DATA_W +: DATA_W];
        assign sh_src[P*ADDR_W +: ADDR_W]  = i_src[i*ADDR_W +: ADDR_W];
    end

    for (genvar j = 0; j < N/2; j++) begin : g_sw
        omega_switch #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BIT(BIT)) u_sw (
            .a_vld (sh_vld[2*j]),
            .a_dst (sh_dst[(2*j)*ADDR_W +: ADDR_W]),
            .a_dat (sh_dat[(2*j)*DATA_W +: DATA_W]),
            .a_src (sh_src[(2*j)*ADDR_W +: ADDR_W]),
            .b_vld (sh_vld[2*j+1]),
            .b_dst (sh_dst[(2*j+1)*ADDR_W +: ADDR_W]),
            .b_dat (sh_dat[(2*j+1)*DATA_W +: DATA_W]),
            .b_src (sh_src[(2*j+1)*ADDR_W +: ADDR_W]),
            .u_vld (o_vld[2*j]),
            .u_dst (o_dst[(2*j)*ADDR_W +: ADDR_W]),
            .u_dat (o_dat[(2*j)*DATA_W +: DATA_W]),
            .u_src (o_src[(2*j)*ADDR_W +: ADDR_W]),
            .l_vld (o_vld[2*j+1]),
            .l_dst (o_dst[(2*j+1)*ADDR_W +: ADDR_W]),
            .l_dat (o_dat[(2*j+1)*DATA_W +: DATA_W]),
            .l_src (o_src[(2*j+1)*ADDR_W +: ADDR_W]),
            .b_lost(lost[j])
        );
    end

    // Map each lost lower-input message back to its source port.
    always_comb begin
        o_blk = '0;
        for (int j = 0; j < N/2; j++)
            if (lost[j])
                o_blk[sh_src[(2*j+1)*ADDR_W +: ADDR_W]] = 1'b1;
    end

endmodule

// File: rtl/omega_net.sv
module omega_net
    import omega_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3,
    localparam int N     = 1 << ADDR_W,
    localparam int S     = ADDR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        in_valid,
    input  logic [N*ADDR_W-1:0] in_dest,
    input  logic [N*DATA_W-1:0] in_data,
    output logic [N-1:0]        out_valid,
    output logic [N*DATA_W-1:0] out_data,
    output logic [N-1:0]        blocked
);

    logic [N-1:0]        st_vld [S+1];
    logic [N*ADDR_W-1:0] st_dst [S+1];
    logic [N*DATA_W-1:0] st_dat [S+1];
    logic [N*ADDR_W-1:0] st_src [S+1];
    logic [N-1:0]        st_blk [S];
    logic [N-1:0]        blk_all;
    logic [N*DATA_W-1:0] dat_masked;

    assign st_vld[0] = in_valid;
    assign st_dst[0] = in_dest;
    assign st_dat[0] = in_data;
    for (genvar i = 0; i < N; i++) begin : g_src
        assign st_src[0][i*ADDR_W +: ADDR_W] = ADDR_W'(i);
    end

    // Stage k steers on destination bit (S-1-k), most significant first.
    for (genvar k = 0; k < S; k++) begin : g_stage
        omega_stage #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BIT(S-1-k)) u_stage (
            .i_vld(st_vld[k]),   .i_dst(st_dst[k]),
            .i_dat(st_dat[k]),   .i_src(st_src[k]),
            .o_vld(st_vld[k+1]), .o_dst(st_dst[k+1]),
            .o_dat(st_dat[k+1]), .o_src(st_src[k+1]),
            .o_blk(st_blk[k])
        );
    end

    always_comb begin
        blk_all = '0;
        for (int k = 0; k < S; k++)
            blk_all = blk_all | st_blk[k];
        for (int o = 0; o < N; o++)
            dat_masked[o*DATA_W +: DATA_W] =
                st_vld[S][o] ? st_dat[S][o*DATA_W +: DATA_W] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= '0;
            out_data  <= '0;
            blocked   <= '0;
        end else begin
            out_valid <= st_vld[S];
            out_data  <= dat_masked;
            blocked   <= blk_all;
        end
    end

    // Gates the checks until one sampled cycle exists after reset.
    logic seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    // R7
    conserve_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        ($countones(out_valid) + $countones(blocked)) == $past($countones(in_valid)));

    // R8
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid == '0) |=> (out_valid == '0 && blocked == '0));

    // R6
    invalid_unblocked_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        (blocked & ~$past(in_valid)) == '0);

    // R2
    lone_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(in_valid) == 1) |=> (blocked == '0 && $countones(out_valid) == 1));

endmodule

// File: tb/sim_omega_net.sv
module sim_omega_net;

    localparam int DW = 8;
    localparam int AW = 3;
    localparam int N  = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    in_valid = '0;
    logic [N*AW-1:0] in_dest = '0;
    logic [N*DW-1:0] in_data = '0;
    logic [N-1:0]    out_valid;
    logic [N*DW-1:0] out_data;
    logic [N-1:0]    blocked;

    int runs = 0;
    int fails = 0;

    always #5 clk = ~clk;

    omega_net #(.DATA_W(DW), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
        .blocked(blocked)
    );

    // {valid, dest nibbles (input i at [4i+:4]), exp out_valid, exp blocked,
    //  exp source nibbles (output o at [4o+:4])}
    localparam logic [87:0] VEC [8] = '{
        {8'hFF, 32'h76543210, 8'hFF, 8'h00, 32'h76543210},  // R3 identity
        {8'hFF, 32'h07654321, 8'hFF, 8'h00, 32'h65432107},  // R3 shift +1
        {8'hFF, 32'h32107654, 8'hFF, 8'h00, 32'h32107654},  // R3 shift +4
        {8'h44, 32'h04000700, 8'h80, 8'h40, 32'h20000000},  // R5 contention
        {8'h40, 32'h04000700, 8'h10, 8'h00, 32'h00060000},  // R6 invalid peer
        {8'hFF, 32'h77777777, 8'h80, 8'hFE, 32'h00000000},  // R9 hot spot
        {8'h09, 32'h00006001, 8'h42, 8'h00, 32'h03000000},  // R4 tag steering
        {8'h00, 32'h77777777, 8'h00, 8'h00, 32'h00000000}   // R8 idle
    };

    function automatic string vtag(input int k);
        case (k)
            0, 1, 2: return "R3";
            3:       return "R5";
            4:       return "R6";
            5:       return "R9";
            6:       return "R4";
            default: return "R8";
        endcase
    endfunction

    function automatic logic [DW-1:0] pl(input int src, input int k);
        return {4'((k + 1) & 15), 4'(src)};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        runs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] v, input logic [31:0] d, input int k);
        @(negedge clk);
        in_valid = v;
        for (int i = 0; i < N; i++) begin
            in_dest[i*AW +: AW] = d[i*4 +: AW];
            in_data[i*DW +: DW] = pl(i, k);
        end
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired (all R)");
        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: held in reset
        chk("R1", "out_valid in reset", 32'(out_valid), 0);
        chk("R1", "blocked in reset", 32'(blocked), 0);
        chk("R1", "out_data in reset", 32'(out_data[31:0] | out_data[63:32]), 0);
        rst_n = 1'b1;

        for (int k = 0; k < 8; k++) begin
            logic [87:0] v;
            v = VEC[k];
            drive(v[87:80], v[79:48], k);
            chk(vtag(k), "out_valid", 32'(out_valid), 32'(v[47:40]));
            chk(vtag(k), "blocked", 32'(blocked), 32'(v[39:32]));
            for (int o = 0; o < N; o++) begin
                if (v[40 + o])
                    chk(vtag(k), "out_data", 32'(out_data[o*DW +: DW]),
                        32'(pl(int'(v[o*4 +: 3]), k)));
                else
                    chk("R6", "idle out_data zero", 32'(out_data[o*DW +: DW]), 0);
            end
        end

        // R2: every single source-to-destination pair
        for (int s = 0; s < N; s++) begin
            for (int d = 0; d < N; d++) begin
                logic [31:0] dn;
                dn = '0;
                dn[s*4 +: 4] = 4'(d);
                drive(8'(1 << s), dn, s + d);
                chk("R2", "single out_valid", 32'(out_valid), 32'(1 << d));
                chk("R2", "single blocked", 32'(blocked), 0);
                chk("R2", "single payload", 32'(out_data[d*DW +: DW]), 32'(pl(s, s + d)));
            end
        end

        // R8: traffic then an idle cycle leaves nothing behind
        drive(8'hFF, 32'h77777777, 2);
        drive(8'h00, 32'h00000000, 3);
        chk("R8", "after idle out_valid", 32'(out_valid), 0);
        chk("R8", "after idle blocked", 32'(blocked), 0);

        // R1: reset in the middle of traffic
        drive(8'hFF, 32'h76543210, 4);
        in_valid = 8'hFF;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "mid-run out_valid", 32'(out_valid), 0);
        chk("R1", "mid-run blocked", 32'(blocked), 0);
        chk("R1", "mid-run out_data", 32'(out_data[31:0] | out_data[63:32]), 0);

        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

endmodule